// File: doc/BRIEF.md
# Bus Transceiver Operating-Mode Sequencer

This block is the digital mode sequencer of a transceiver for a serial bus that carries its clock alongside its data. The same block serves a master node or a slave node. A select pin picks the role. It watches five things: a sleep-control pin, the role select, an over-temperature flag, a one-cycle pulse for each bus clock that is detected, and the raw level of the bus. From these it keeps one of four modes: Sleep, Standby, Normal and Thermal shutdown.

The current mode decides what passes through. It sets whether host transmit data and the master's baud-rate clock reach the bus. It sets whether the receive pin sees decoded data, the raw bus, or an idle level. In a slave it also sets whether the clock pin carries the decoded bus clock or the raw bus. On the way from Sleep to Normal the block stays in Standby for a baud-rate learning window of a set number of bus clocks. Over-temperature cuts only the host-to-bus direction and leaves reception working. When the flag clears, the block resumes the mode it had before the shutdown. In Sleep, a falling edge on the bus raises a one-cycle wake pulse.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset the mode output reads Sleep. The mode codes are Sleep=2'b00, Standby=2'b01, Normal=2'b10 and Thermal=2'b11.
- R2: If the thermal flag is clear, the mode is not Thermal and sleep-control is sampled low, the next mode is Sleep, whatever the current mode.
- R3: From Sleep with sleep-control high, the next mode is Standby. Normal is never entered directly from Sleep.
- R4: In Standby the block counts bus clock pulses, default three. The mode becomes Normal on the clock edge that samples the final pulse. With fewer pulses it stays in Standby.
- R5: In Normal, bus_tx_o follows host_tx_i and rx_o follows bus_rx_dec_i. In every other mode bus_tx_o holds the recessive level 1.
- R6: In Thermal, bus_tx_o and bus_clk_drv_o hold 1, while rx_o still follows bus_rx_dec_i.
- R7: A sampled-high thermal flag makes the next mode Thermal from any mode, whatever the sleep-control level.
- R8: When the flag is sampled low in Thermal, the next mode is the one held before shutdown. A partly completed Standby pulse count resumes from where it stopped.
- R9: A master in Sleep passes the raw bus level to rx_o. A slave in Sleep, and either role in Standby, holds rx_o at 1.
- R10: A slave drives the clock pin (clk_out_en_o=1). The pin carries bus_clk_dec_i while sleep-control is high and bus_rx_raw_i while it is low. A master has clk_out_en_o=0 and clk_out_o=0.
- R11: A master forwards master_clk_i to bus_clk_drv_o in Standby and Normal. Otherwise bus_clk_drv_o is 1.
- R12: wake_o pulses for one cycle after an edge that samples the raw bus low, when the previous sample was high and the mode is Sleep. It never pulses outside Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_ctl_i | input | 1 | 0 forces Sleep, 1 allows Standby/Normal |
| role_slave_i | input | 1 | 1 = slave node, 0 = master node |
| overtemp_i | input | 1 | Over-temperature flag |
| bus_clk_pulse_i | input | 1 | One-cycle pulse per detected bus clock |
| bus_rx_raw_i | input | 1 | Raw (undecoded) bus level |
| bus_rx_dec_i | input | 1 | Decoded bus data |
| bus_clk_dec_i | input | 1 | Decoded bus clock |
| host_tx_i | input | 1 | Host transmit data |
| master_clk_i | input | 1 | Baud-rate clock from host (master) |
| bus_tx_o | output | 1 | Data toward the bus encoder, 1 = recessive |
| bus_clk_drv_o | output | 1 | Clock toward the bus driver (master) |
| rx_o | output | 1 | Receive data toward host |
| clk_out_o | output | 1 | Clock pin value when driven |
| clk_out_en_o | output | 1 | Clock pin drive enable |
| wake_o | output | 1 | Wake-up pulse |
| mode_o | output | 2 | Current mode code |

## Verification
For each role and each mode, the bench sweeps all 32 combinations of the five data inputs. A design that let host data or the master clock through in Thermal, or that muted reception there, fails in that sweep. The Standby learning window is cut by a shutdown after one pulse. A design that drops or restarts the count, or that skips Standby, then reaches Normal on the wrong edge. The flag is raised while sleep-control is low, which catches a design that gives Sleep priority over Thermal or does not resume the saved mode. A falling bus edge is presented both inside and outside Sleep, which catches a wake detector that is not gated by mode.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_STBY  = 2'b01,
        MODE_NORM  = 2'b10,
        MODE_THERM = 2'b11
    } mode_e;

    localparam logic TX_RECESSIVE = 1'b1;

endpackage

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int DETECT_CLKS = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_ctl_i,
    input  logic  overtemp_i,
    input  logic  bus_clk_pulse_i,
    output mode_e mode_o
);
    localparam int CW = $clog2(DETECT_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DETECT_CLKS - 1);

    typedef struct packed {
        mode_e         mode;
        mode_e         saved;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (overtemp_i) begin
            if (st_q.mode != MODE_THERM) begin
                st_d.saved = st_q.mode;
                st_d.mode  = MODE_THERM;
            end
        end else if (st_q.mode == MODE_THERM) begin
            st_d.mode = st_q.saved;
        end else if (!sleep_ctl_i) begin
            st_d.mode = MODE_SLEEP;
            st_d.cnt  = '0;
        end else begin
            unique case (st_q.mode)
                MODE_SLEEP: begin
                    st_d.mode = MODE_STBY;
                    st_d.cnt  = '0;
                end
                MODE_STBY: begin
                    if (bus_clk_pulse_i) begin
                        if (st_q.cnt == LAST) begin
                            st_d.mode = MODE_NORM;
                            st_d.cnt  = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: st_d.mode = st_q.mode;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SLEEP, saved: MODE_SLEEP, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    AST_SLEEP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!overtemp_i && st_q.mode != MODE_THERM && !sleep_ctl_i) |=> (st_q.mode == MODE_SLEEP)); // R2
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SLEEP) |=> (st_q.mode != MODE_NORM)); // R3
    AST_THERM_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp_i |=> (st_q.mode == MODE_THERM)); // R7
    AST_THERM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_THERM && !overtemp_i) |=> (st_q.mode == $past(st_q.saved))); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt <= LAST)); // R4
endmodule

// File: rtl/xcvr_path_gate.sv
module xcvr_path_gate
    import xcvr_mode_pkg::*;
(
    input  mode_e mode_i,
    input  logic  role_slave_i,
    input  logic  sleep_ctl_i,
    input  logic  host_tx_i,
    input  logic  master_clk_i,
    input  logic  bus_rx_raw_i,
    input  logic  bus_rx_dec_i,
    input  logic  bus_clk_dec_i,
    output logic  bus_tx_o,
    output logic  bus_clk_drv_o,
    output logic  rx_o,
    output logic  clk_out_o,
    output logic  clk_out_en_o
);
    always_comb begin
        bus_tx_o      = TX_RECESSIVE;
        bus_clk_drv_o = 1'b1;
        rx_o          = 1'b1;
        unique case (mode_i)
            MODE_SLEEP: rx_o = role_slave_i ? 1'b1 : bus_rx_raw_i;
            MODE_STBY: begin
                if (!role_slave_i) bus_clk_drv_o = master_clk_i;
            end
            MODE_NORM: begin
                bus_tx_o = host_tx_i;
                rx_o     = bus_rx_dec_i;
                if (!role_slave_i) bus_clk_drv_o = master_clk_i;
            end
            MODE_THERM: rx_o = bus_rx_dec_i;
            default: rx_o = 1'b1;
        endcase
    end

    always_comb begin
        clk_out_en_o = role_slave_i;
        if (!role_slave_i)    clk_out_o = 1'b0;
        else if (sleep_ctl_i) clk_out_o = bus_clk_dec_i;
        else                  clk_out_o = bus_rx_raw_i;
    end
endmodule

// File: rtl/xcvr_wake_det.sv
module xcvr_wake_det
    import xcvr_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode_i,
    input  logic  bus_rx_raw_i,
    output logic  wake_o
);
    typedef struct packed {
        logic raw;
        logic wake;
    } wk_t;

    wk_t wk_d, wk_q;

    always_comb begin
        wk_d.raw  = bus_rx_raw_i;
        wk_d.wake = (mode_i == MODE_SLEEP) && wk_q.raw && !bus_rx_raw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '{raw: 1'b1, wake: 1'b0};
        else        wk_q <= wk_d;
    end

    assign wake_o = wk_q.wake;

    AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(mode_i) == MODE_SLEEP)); // R12
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o); // R12
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int DETECT_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_ctl_i,
    input  logic       role_slave_i,
    input  logic       overtemp_i,
    input  logic       bus_clk_pulse_i,
    input  logic       bus_rx_raw_i,
    input  logic       bus_rx_dec_i,
    input  logic       bus_clk_dec_i,
    input  logic       host_tx_i,
    input  logic       master_clk_i,
    output logic       bus_tx_o,
    output logic       bus_clk_drv_o,
    output logic       rx_o,
    output logic       clk_out_o,
    output logic       clk_out_en_o,
    output logic       wake_o,
    output logic [1:0] mode_o
);
    mode_e mode_q;

    xcvr_mode_fsm #(.DETECT_CLKS(DETECT_CLKS)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sleep_ctl_i     (sleep_ctl_i),
        .overtemp_i      (overtemp_i),
        .bus_clk_pulse_i (bus_clk_pulse_i),
        .mode_o          (mode_q)
    );

    xcvr_path_gate u_gate (
        .mode_i        (mode_q),
        .role_slave_i  (role_slave_i),
        .sleep_ctl_i   (sleep_ctl_i),
        .host_tx_i     (host_tx_i),
        .master_clk_i  (master_clk_i),
        .bus_rx_raw_i  (bus_rx_raw_i),
        .bus_rx_dec_i  (bus_rx_dec_i),
        .bus_clk_dec_i (bus_clk_dec_i),
        .bus_tx_o      (bus_tx_o),
        .bus_clk_drv_o (bus_clk_drv_o),
        .rx_o          (rx_o),
        .clk_out_o     (clk_out_o),
        .clk_out_en_o  (clk_out_en_o)
    );

    xcvr_wake_det u_wake (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_q),
        .bus_rx_raw_i (bus_rx_raw_i),
        .wake_o       (wake_o)
    );

    assign mode_o = mode_q;

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b10) |-> bus_tx_o); // R5
    AST_THERM_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11) |-> bus_clk_drv_o); // R6
endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_ctl = 1'b0, role_slave = 1'b0, overtemp = 1'b0, clk_pulse = 1'b0;
    logic raw = 1'b1, dec = 1'b1, dclk = 1'b0, htx = 1'b1, mclk = 1'b0;
    logic bus_tx, bus_clk_drv, rx, clk_out, clk_en, wake;
    logic [1:0] mode;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_ctl_i(sleep_ctl), .role_slave_i(role_slave),
        .overtemp_i(overtemp), .bus_clk_pulse_i(clk_pulse), .bus_rx_raw_i(raw),
        .bus_rx_dec_i(dec), .bus_clk_dec_i(dclk), .host_tx_i(htx), .master_clk_i(mclk),
        .bus_tx_o(bus_tx), .bus_clk_drv_o(bus_clk_drv), .rx_o(rx), .clk_out_o(clk_out),
        .clk_out_en_o(clk_en), .wake_o(wake), .mode_o(mode)
    );

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_clk();
        clk_pulse = 1'b1;
        tick();
        clk_pulse = 1'b0;
    endtask

    // Exhaustive sweep of data inputs within the current mode m.
    task automatic sweep(logic [1:0] m);
        for (int i = 0; i < 32; i++) begin
            logic e_tx, e_drv, e_rx, e_co;
            {htx, mclk, raw, dec, dclk} = 5'(i);
            #1;
            e_tx  = (m == 2'b10) ? htx : 1'b1;
            e_drv = (!role_slave && (m == 2'b01 || m == 2'b10)) ? mclk : 1'b1;
            e_rx  = (m == 2'b10 || m == 2'b11) ? dec : ((m == 2'b00 && !role_slave) ? raw : 1'b1);
            e_co  = role_slave ? (sleep_ctl ? dclk : raw) : 1'b0;
            chk((m == 2'b11) ? "R6 tx" : "R5 tx", 2'(bus_tx), 2'(e_tx));
            chk((m == 2'b11) ? "R6 clkdrv" : "R11 clkdrv", 2'(bus_clk_drv), 2'(e_drv));
            chk((m == 2'b00 || m == 2'b01) ? "R9 rx" : "R5 rx", 2'(rx), 2'(e_rx));
            chk("R10 clk pin", 2'(clk_out), 2'(e_co));
            chk("R10 clk en", 2'(clk_en), 2'(role_slave));
        end
        raw = 1'b1;
        #1;
    endtask

    initial begin
        for (int r = 0; r < 2; r++) begin
            role_slave = r[0];
            sleep_ctl = 1'b0; overtemp = 1'b0; clk_pulse = 1'b0; raw = 1'b1;
            rst_n = 1'b0;
            tick(); tick();
            rst_n = 1'b1;
            chk("R1 reset mode", mode, 2'b00);
            chk("R12 reset wake", 2'(wake), 2'b00);
            tick();
            chk("R1 sleep held", mode, 2'b00);
            sweep(2'b00);
            // R12 wake in Sleep
            raw = 1'b1; tick();
            raw = 1'b0; tick();
            chk("R12 wake pulse", 2'(wake), 2'b01);
            tick();
            chk("R12 wake single", 2'(wake), 2'b00);
            raw = 1'b1; tick();
            // R3 wake to Standby
            sleep_ctl = 1'b1; tick();
            chk("R3 standby", mode, 2'b01);
            sweep(2'b01);
            // R4 partial count, R8 resume after thermal
            pulse_clk();
            chk("R4 one pulse", mode, 2'b01);
            overtemp = 1'b1; tick();
            chk("R7 thermal from standby", mode, 2'b11);
            sweep(2'b11);
            overtemp = 1'b0; tick();
            chk("R8 back to standby", mode, 2'b01);
            pulse_clk();
            chk("R4 two pulses", mode, 2'b01);
            tick();
            chk("R4 no pulse stays", mode, 2'b01);
            pulse_clk();
            chk("R4 normal after three", mode, 2'b10);
            sweep(2'b10);
            // R12 no wake outside Sleep
            raw = 1'b1; tick();
            raw = 1'b0; tick();
            chk("R12 no wake in normal", 2'(wake), 2'b00);
            raw = 1'b1; tick();
            // R7 priority over sleep control, R8 return to Normal
            overtemp = 1'b1; sleep_ctl = 1'b0; tick();
            chk("R7 thermal over sleep", mode, 2'b11);
            sweep(2'b11);
            overtemp = 1'b0; tick();
            chk("R8 back to normal", mode, 2'b10);
            tick();
            chk("R2 normal to sleep", mode, 2'b00);
            sleep_ctl = 1'b1; tick();
            chk("R3 standby again", mode, 2'b01);
            sleep_ctl = 1'b0; tick();
            chk("R2 standby to sleep", mode, 2'b00);
            // Count must restart after Sleep
            sleep_ctl = 1'b1; tick();
            pulse_clk(); pulse_clk();
            chk("R4 restart count", mode, 2'b01);
            pulse_clk();
            chk("R4 normal again", mode, 2'b10);
            overtemp = 1'b1; tick();
            chk("R7 thermal from normal", mode, 2'b11);
            overtemp = 1'b0;
            sleep_ctl = 1'b0; tick(); tick();
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule